// File: doc/BRIEF.md
# CPU Status and Reset-Cause Register

This block is an 8-bit status register for a processor core. It holds one software control bit, the global interrupt disable. Around that bit it keeps a set of flags that hardware maintains. Software reads the flags to learn four things:

- why the device last came out of reset;
- whether the watchdog expired;
- whether the core went into power-down;
- whether the return stack overflowed.

Each flag follows its own set and clear rule. The rules are driven by reset-type pulses and by single-cycle core events: a watchdog clear, a sleep, a watchdog time-out and a stack overflow.

A power-on reset drives the synchronous `rst` input and loads every bit with its power-up value. External, watchdog and brown-out resets are separate pulses. They restore the interrupt disable and stack flags but leave the reset-cause flags in place, so software can tell which reset occurred.

A bus write changes only the three writable bits. A hardware event on the same bit in the same cycle takes precedence over the write. The read value and the interrupt-disable level come straight from flip-flops.

Top module: `cpu_stat_reg`

## Requirements
- R1: Read bits 7 and 6 are always 0. Bits 5 down to 0 hold, in order: stack-ok, interrupt-disable, no-timeout, awake, no-power-on flag, no-brown-out flag.
- R2: After power-on reset (`rst` high at a clock edge) the read value is 8'h3D.
- R3: A write (`wr_en` high, no reset pulse) loads bits 4, 1 and 0 from `wr_data` bits 4, 1 and 0 at the next edge.
- R4: Writes have no effect on bits 5, 3 and 2.
- R5: A stack-overflow event clears bit 5. Writes cannot set it again; only a reset (power-on, external, watchdog or brown-out) does.
- R6: A watchdog time-out clears bit 3 and a watchdog clear sets it. When both come in the same cycle, bit 3 is 0.
- R7: A sleep event clears bit 2 and a watchdog clear sets it. When both come in the same cycle, bit 2 is 0.
- R8: A brown-out reset clears bit 0 while `bor_det_en` is 1. While `bor_det_en` is 0, a brown-out reset leaves bit 0 unchanged.
- R9: An external, watchdog or brown-out reset sets bits 5 and 4. It keeps bit 1 and leaves bits 3 and 2 to the events. A bus write in that cycle is ignored.
- R10: A hardware event beats a bus write on the same bit in the same cycle. For example, an enabled brown-out reset together with a write of 1 to bit 0 leaves bit 0 at 0.
- R11: `int_gbl_dis` always equals read bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| ext_rst | input | 1 | External reset pulse |
| wdt_rst | input | 1 | Watchdog reset pulse |
| bor_rst | input | 1 | Brown-out reset pulse |
| bor_det_en | input | 1 | Brown-out detection enabled (configuration level) |
| clrwdt_evt | input | 1 | Watchdog clear event strobe |
| sleep_evt | input | 1 | Sleep event strobe |
| wdt_tmo_evt | input | 1 | Watchdog time-out event strobe |
| stk_ovf_evt | input | 1 | Stack overflow event strobe |
| wr_en | input | 1 | Bus write enable |
| wr_data | input | 8 | Bus write data |
| rd_data | output | 8 | Register read value |
| int_gbl_dis | output | 1 | Global interrupt disable level |

## Verification
The bench writes all 256 data values. This shows that exactly bits 4, 1 and 0 follow the data, while the read-only bits and the top two bits stay put. It then runs all eight combinations of watchdog clear, sleep and time-out, starting both from the cleared state and from the set state. That separates set-wins from clear-wins ordering on bits 3 and 2. Reset pulses are combined with conflicting writes and with `bor_det_en` at both levels. This separates a power-on reset from a device reset, and an enabled brown-out from a disabled one, on the reset-cause flags.

// File: rtl/cpu_stat_pkg.sv
package cpu_stat_pkg;
  localparam int DATA_W  = 8;
  localparam int B_STK   = 5;
  localparam int B_GID   = 4;
  localparam int B_TO    = 3;
  localparam int B_PD    = 2;
  localparam int B_PORF  = 1;
  localparam int B_BORF  = 0;
  localparam int FLAG_N  = 6;
  localparam logic [DATA_W-1:0] POR_VALUE = 8'h3D;
endpackage

// File: rtl/cs_reset_decode.sv
module cs_reset_decode (
  input  logic ext_rst,
  input  logic wdt_rst,
  input  logic bor_rst,
  input  logic bor_det_en,
  input  logic wr_en,
  output logic dev_rst,
  output logic bor_clr,
  output logic wr_ok
);
  // any non-power-on device reset
  assign dev_rst = ext_rst | wdt_rst | bor_rst;
  // brown-out only recorded when detection is enabled
  assign bor_clr = bor_rst & bor_det_en;
  // writes are dropped during any device reset
  assign wr_ok   = wr_en & ~dev_rst;
endmodule

// File: rtl/cs_flag_bit.sv
module cs_flag_bit #(
  parameter logic POR_VAL  = 1'b1,
  parameter bit   DEV_LOAD = 1'b0,
  parameter logic DEV_VAL  = 1'b1,
  parameter bit   WRITABLE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic dev_rst,
  input  logic clr,
  input  logic set,
  input  logic wr_en,
  input  logic wr_val,
  output logic q
);
  // priority: power-on, device reset, clear event, set event, bus write
  always_ff @(posedge clk) begin
    if (rst)                        q <= POR_VAL;
    else if (DEV_LOAD && dev_rst)   q <= DEV_VAL;
    else if (clr)                   q <= 1'b0;
    else if (set)                   q <= 1'b1;
    else if (WRITABLE && wr_en)     q <= wr_val;
  end
endmodule

// File: rtl/cpu_stat_reg.sv
module cpu_stat_reg
  import cpu_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_rst,
  input  logic              wdt_rst,
  input  logic              bor_rst,
  input  logic              bor_det_en,
  input  logic              clrwdt_evt,
  input  logic              sleep_evt,
  input  logic              wdt_tmo_evt,
  input  logic              stk_ovf_evt,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              int_gbl_dis
);
  logic dev_rst, bor_clr, wr_ok;
  logic [FLAG_N-1:0] flag_q;
  logic unused_wr_hi;

  assign unused_wr_hi = &{1'b0, wr_data[DATA_W-1:FLAG_N]};

  cs_reset_decode u_dec (
    .ext_rst(ext_rst), .wdt_rst(wdt_rst), .bor_rst(bor_rst),
    .bor_det_en(bor_det_en), .wr_en(wr_en),
    .dev_rst(dev_rst), .bor_clr(bor_clr), .wr_ok(wr_ok)
  );

  // stack-ok: sticky clear, restored by any reset
  cs_flag_bit #(.POR_VAL(1'b1), .DEV_LOAD(1'b1), .DEV_VAL(1'b1), .WRITABLE(1'b0)) u_stk (
    .clk(clk), .rst(rst), .dev_rst(dev_rst), .clr(stk_ovf_evt), .set(1'b0),
    .wr_en(wr_ok), .wr_val(wr_data[B_STK]), .q(flag_q[B_STK])
  );

  // interrupt disable: software bit, forced high by device reset
  cs_flag_bit #(.POR_VAL(1'b1), .DEV_LOAD(1'b1), .DEV_VAL(1'b1), .WRITABLE(1'b1)) u_gid (
    .clk(clk), .rst(rst), .dev_rst(dev_rst), .clr(1'b0), .set(1'b0),
    .wr_en(wr_ok), .wr_val(wr_data[B_GID]), .q(flag_q[B_GID])
  );

  // no-timeout: clear on time-out beats set on watchdog clear
  cs_flag_bit #(.POR_VAL(1'b1), .DEV_LOAD(1'b0), .DEV_VAL(1'b1), .WRITABLE(1'b0)) u_to (
    .clk(clk), .rst(rst), .dev_rst(dev_rst), .clr(wdt_tmo_evt), .set(clrwdt_evt),
    .wr_en(wr_ok), .wr_val(wr_data[B_TO]), .q(flag_q[B_TO])
  );

  // awake: clear on sleep beats set on watchdog clear
  cs_flag_bit #(.POR_VAL(1'b1), .DEV_LOAD(1'b0), .DEV_VAL(1'b1), .WRITABLE(1'b0)) u_pd (
    .clk(clk), .rst(rst), .dev_rst(dev_rst), .clr(sleep_evt), .set(clrwdt_evt),
    .wr_en(wr_ok), .wr_val(wr_data[B_PD]), .q(flag_q[B_PD])
  );

  // no-power-on flag: 0 after power-on, only software sets it
  cs_flag_bit #(.POR_VAL(1'b0), .DEV_LOAD(1'b0), .DEV_VAL(1'b1), .WRITABLE(1'b1)) u_porf (
    .clk(clk), .rst(rst), .dev_rst(dev_rst), .clr(1'b0), .set(1'b0),
    .wr_en(wr_ok), .wr_val(wr_data[B_PORF]), .q(flag_q[B_PORF])
  );

  // no-brown-out flag: cleared by an enabled brown-out reset
  cs_flag_bit #(.POR_VAL(1'b1), .DEV_LOAD(1'b0), .DEV_VAL(1'b1), .WRITABLE(1'b1)) u_borf (
    .clk(clk), .rst(rst), .dev_rst(dev_rst), .clr(bor_clr), .set(1'b0),
    .wr_en(wr_ok), .wr_val(wr_data[B_BORF]), .q(flag_q[B_BORF])
  );

  assign rd_data     = {{(DATA_W-FLAG_N){1'b0}}, flag_q};
  assign int_gbl_dis = flag_q[B_GID];
endmodule

// File: rtl/cpu_stat_reg_chk.sv
module cpu_stat_reg_chk (
  input logic       clk,
  input logic       rst,
  input logic       ext_rst,
  input logic       wdt_rst,
  input logic       bor_rst,
  input logic       bor_det_en,
  input logic       clrwdt_evt,
  input logic       sleep_evt,
  input logic       wdt_tmo_evt,
  input logic       stk_ovf_evt,
  input logic       wr_en,
  input logic [7:0] rd_data,
  input logic       int_gbl_dis
);
  logic any_dev;
  assign any_dev = ext_rst | wdt_rst | bor_rst;

  AST_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_data[7:6] == 2'b00); // R1
  AST_RO_STABLE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !any_dev && !clrwdt_evt && !sleep_evt && !wdt_tmo_evt && !stk_ovf_evt)
    |=> ($stable(rd_data[5]) && $stable(rd_data[3:2]))); // R4
  AST_STK_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!rd_data[5] && !any_dev) |=> !rd_data[5]); // R5
  AST_TMO_CLEARS: assert property (@(posedge clk) disable iff (rst)
    wdt_tmo_evt |=> !rd_data[3]); // R6
  AST_SLEEP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    sleep_evt |=> !rd_data[2]); // R7
  AST_BOR_RECORD: assert property (@(posedge clk) disable iff (rst)
    (bor_rst && bor_det_en) |=> !rd_data[0]); // R8
  AST_BOR_MASKED: assert property (@(posedge clk) disable iff (rst)
    (bor_rst && !bor_det_en) |=> $stable(rd_data[0])); // R8
  AST_DEV_RESTORE: assert property (@(posedge clk) disable iff (rst)
    any_dev |=> (rd_data[5] && rd_data[4] && $stable(rd_data[1]))); // R9
  AST_GID_PIN: assert property (@(posedge clk) disable iff (rst)
    int_gbl_dis == rd_data[4]); // R11
endmodule

bind cpu_stat_reg cpu_stat_reg_chk u_chk (
  .clk(clk), .rst(rst), .ext_rst(ext_rst), .wdt_rst(wdt_rst), .bor_rst(bor_rst),
  .bor_det_en(bor_det_en), .clrwdt_evt(clrwdt_evt), .sleep_evt(sleep_evt),
  .wdt_tmo_evt(wdt_tmo_evt), .stk_ovf_evt(stk_ovf_evt), .wr_en(wr_en),
  .rd_data(rd_data), .int_gbl_dis(int_gbl_dis)
);

// File: tb/cpu_stat_reg_tb.sv
`timescale 1ns/1ps
module cpu_stat_reg_tb;
  logic clk = 1'b0;
  logic rst, ext_rst, wdt_rst, bor_rst, bor_det_en;
  logic clrwdt_evt, sleep_evt, wdt_tmo_evt, stk_ovf_evt, wr_en;
  logic [7:0] wr_data, rd_data;
  logic int_gbl_dis;
  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q;

  always #4 clk = ~clk;

  cpu_stat_reg u_dut (
    .clk(clk), .rst(rst), .ext_rst(ext_rst), .wdt_rst(wdt_rst), .bor_rst(bor_rst),
    .bor_det_en(bor_det_en), .clrwdt_evt(clrwdt_evt), .sleep_evt(sleep_evt),
    .wdt_tmo_evt(wdt_tmo_evt), .stk_ovf_evt(stk_ovf_evt), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .int_gbl_dis(int_gbl_dis)
  );

  // expected next value, built from the requirement text
  function automatic logic [7:0] model(input logic [7:0] q);
    logic [7:0] n;
    logic dev;
    n = q;
    dev = ext_rst | wdt_rst | bor_rst;
    if (wr_en && !dev) begin
      n[4] = wr_data[4]; n[1] = wr_data[1]; n[0] = wr_data[0];      // R3
    end
    if (stk_ovf_evt) n[5] = 1'b0;                                   // R5
    if (dev) begin n[5] = 1'b1; n[4] = 1'b1; end                    // R9
    if (bor_rst && bor_det_en) n[0] = 1'b0;                         // R8
    if (clrwdt_evt) begin n[3] = 1'b1; n[2] = 1'b1; end
    if (wdt_tmo_evt) n[3] = 1'b0;                                   // R6
    if (sleep_evt) n[2] = 1'b0;                                     // R7
    n[7:6] = 2'b00;                                                 // R1
    return n;
  endfunction

  task automatic idle();
    ext_rst = 0; wdt_rst = 0; bor_rst = 0; clrwdt_evt = 0; sleep_evt = 0;
    wdt_tmo_evt = 0; stk_ovf_evt = 0; wr_en = 0; wr_data = 8'h00;
  endtask

  task automatic check(input string req);
    n_chk++;
    if (rd_data !== exp_q || int_gbl_dis !== exp_q[4]) begin
      n_fail++;
      $display("FAIL %s: rd=%h gid=%b expected rd=%h gid=%b", req, rd_data, int_gbl_dis, exp_q, exp_q[4]);
    end
  endtask

  // inputs were set after a falling edge; update model, clock, sample later
  task automatic step(input string req);
    exp_q = model(exp_q);
    @(posedge clk); #2;
    idle();
    check(req);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v, input string req);
    wr_en = 1; wr_data = v; step(req);
  endtask

  initial begin
    #(8 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle(); bor_det_en = 1; rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
    exp_q = 8'h3D;
    check("R2 power-on value");

    // full write sweep
    for (int v = 0; v < 256; v++) wr(v[7:0], "R3 R4 R1 R11 write sweep");

    // event sweep from both end states
    for (int s = 0; s < 2; s++)
      for (int e = 0; e < 8; e++) begin
        if (s == 0) begin wdt_tmo_evt = 1; sleep_evt = 1; end
        else clrwdt_evt = 1;
        step("R6 R7 preset");
        clrwdt_evt = e[0]; sleep_evt = e[1]; wdt_tmo_evt = e[2];
        step("R6 R7 event combination");
      end

    // stack overflow is sticky against writes
    stk_ovf_evt = 1; step("R5 overflow clears");
    wr(8'hFF, "R5 write cannot restore");
    stk_ovf_evt = 1; wr_en = 1; wr_data = 8'hFF; step("R5 overflow with write");
    ext_rst = 1; step("R9 external reset restores stack");

    // device resets keep cause flags and drop writes
    wr(8'h03, "R3 set cause flags, clear gid");
    ext_rst = 1; wr_en = 1; wr_data = 8'h00; step("R9 external reset ignores write");
    wr(8'h03, "R3 clear gid again");
    wdt_rst = 1; step("R9 watchdog reset");

    // brown-out with and without detection
    bor_rst = 1; wr_en = 1; wr_data = 8'h01; step("R8 R10 brown-out beats write");
    wr(8'h01, "R3 software sets brown-out flag");
    bor_det_en = 0;
    bor_rst = 1; step("R8 brown-out masked");
    wr(8'h00, "R3 clear flag");
    bor_rst = 1; step("R8 brown-out masked keeps 0");
    bor_det_en = 1;

    // return to power-on
    rst = 1; @(posedge clk); #2; rst = 0;
    exp_q = 8'h3D; check("R2 power-on again");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule